// File: doc/BRIEF.md
# Real-time counter with compare channels

This block is a count-mode real-time counter for a single clock domain. A separate prescaler supplies a one-cycle tick enable. The counter advances by one on each tick while it is running. It has two widths that share one counting engine. In the 32-bit width the count wraps at its all-ones value, and a match on compare 0 can optionally clear it. In the 16-bit width the count wraps when it reaches a programmable period value.

The block has six compare registers. All six are active in the 16-bit width, and only the lowest four are active in the 32-bit width. A match on a compare, or an overflow, always sets a sticky interrupt flag. It also raises a one-cycle event pulse when that source's bit is set in the event mask. Software uses a small word-wide register port to program the count, the period, the compares, the control bits and the event mask, to read them back, and to clear flags by writing ones.

Top module: `rtc_counter`

## Requirements
- R1: Register map, addressed by `reg_addr`: control at 0, count at 1, period at 2, flags at 3, event mask at 4, and compare k at 8+k. Control bit 0 runs the counter, bit 1 selects the width (1 = 32-bit, 0 = 16-bit) and bit 2 enables clear-on-match. In flags, events and the event mask, bit k is compare k and bit 6 is overflow. After reset, control reads 0x2, and the count, compares, flags, event mask and event outputs are all zero.
- R2: While running, the count rises by exactly one on each clock edge at which `tick` is high. It does not change when `tick` is low or when the counter is stopped.
- R3: In the 32-bit width without clear-on-match, a tick at count 0xFFFFFFFF sets the count to 0 and sets the overflow flag.
- R4: In the 16-bit width, a tick while the low 16 bits of the count equal the period sets the count to 0 and sets the overflow flag. Before that point no overflow is flagged.
- R5: A tick while the count equals compare k sets flag k on that same clock edge. The comparison uses the full 32 bits in the 32-bit width and the low 16 bits in the 16-bit width. Compares 0 to 5 are active in the 16-bit width, and only compares 0 to 3 are active in the 32-bit width.
- R6: With clear-on-match set in the 32-bit width, a tick matching compare 0 sets the count to 0. In the 16-bit width the bit has no effect.
- R7: An event output bit is high for exactly one cycle, in the cycle after the edge that sets the matching flag, and only when that source's event mask bit is set.
- R8: Writing to the flags address clears each flag whose data bit is one. A zero data bit leaves its flag unchanged.
- R9: A write to the count in the same cycle as a tick loads the written value. That tick then neither advances the count nor raises any flag.
- R10: The event mask changes only when it is written while the counter is stopped. Writes made while the counter is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| irq_flags | output | 7 | Sticky flags: compares 0 to 5, overflow at bit 6 |
| evt_out | output | 7 | One-cycle event pulses, same bit order as the flags |

## Verification
The embedded assertions check the following on every cycle:
- the count holds whenever there is no running tick and no count write;
- a rising overflow flag coincides with a zero count;
- compares 4 and 5 never flag in the 32-bit width;
- every event pulse has its flag set and its mask bit enabled;
- the event mask is stable while the counter runs;
- a count write lands as written.

Other behaviour can only be shown by the bench scenarios:
- the exact values at the two wrap points;
- clear-on-match acting in one width and not in the other;
- partial write-one-to-clear patterns;
- the suppression of a tick by a simultaneous count write;
- which channels fire in each width.

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CW     = 32,
  parameter int PW     = 16,
  parameter int NCMP16 = 6,
  parameter int NCMP32 = 4,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  output logic [NCMP16:0]   irq_flags,
  output logic [NCMP16:0]   evt_out
);
  localparam int NSRC = NCMP16 + 1;
  localparam int OVF  = NCMP16;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_PER  = AW'(2);
  localparam logic [AW-1:0] A_FLG  = AW'(3);
  localparam logic [AW-1:0] A_EVM  = AW'(4);
  localparam int A_CMP = 8;

  logic run, wide, clr_on_match;
  logic [CW-1:0] cnt;
  logic [PW-1:0] per;
  logic [CW-1:0] cmp [NCMP16];
  logic [NSRC-1:0] flags, evmask, evt;
  logic [NCMP16-1:0] hit;

  wire cnt_wr  = reg_wr && reg_addr == A_CNT;
  wire adv     = run && tick && !cnt_wr;
  wire [PW-1:0] cnt_lo = cnt[PW-1:0];
  wire wrap16  = !wide && cnt_lo == per;
  wire wrapmax = wide && (&cnt);
  wire ovf_hit = adv && (wrap16 || wrapmax);
  wire clr_hit = wide && clr_on_match && hit[0];
  wire [NSRC-1:0] set_v = {ovf_hit, hit};
  wire [NSRC-1:0] clr_v = (reg_wr && reg_addr == A_FLG) ? reg_wdata[NSRC-1:0] : '0;

  for (genvar k = 0; k < NCMP16; k++) begin : g_cmp
    localparam bit LIVE32 = (k < NCMP32);
    wire live = wide ? LIVE32 : 1'b1;
    wire eq   = wide ? (cmp[k] == cnt) : (cmp[k][PW-1:0] == cnt_lo);
    assign hit[k] = adv && live && eq;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cmp[k] <= '0;
      else if (reg_wr && reg_addr == AW'(A_CMP + k)) cmp[k] <= reg_wdata;

    if (k >= NCMP32) begin : g_hi
      AST_HI_CH_IDLE32: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[k]) |-> !$past(wide)); // R5
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; wide <= 1'b1; clr_on_match <= 1'b0;
      per <= '1; evmask <= '0; flags <= '0; evt <= '0; cnt <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) {clr_on_match, wide, run} <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_PER) per <= reg_wdata[PW-1:0];
      if (reg_wr && reg_addr == A_EVM && !run) evmask <= reg_wdata[NSRC-1:0];
      flags <= (flags & ~clr_v) | set_v;
      evt   <= set_v & evmask;
      if (cnt_wr)
        cnt <= wide ? reg_wdata : {{(CW-PW){1'b0}}, reg_wdata[PW-1:0]};
      else if (adv) begin
        if (ovf_hit || clr_hit) cnt <= '0;
        else if (wide)          cnt <= cnt + 1'b1;
        else                    cnt <= {{(CW-PW){1'b0}}, cnt_lo + 1'b1};
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = CW'({clr_on_match, wide, run});
      A_CNT:   reg_rdata = cnt;
      A_PER:   reg_rdata = CW'(per);
      A_FLG:   reg_rdata = CW'(flags);
      A_EVM:   reg_rdata = CW'(evmask);
      default: ;
    endcase
    for (int k = 0; k < NCMP16; k++)
      if (reg_addr == AW'(A_CMP + k)) reg_rdata = cmp[k];
  end

  assign irq_flags = flags;
  assign evt_out   = evt;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !cnt_wr) |=> $stable(cnt)); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[OVF]) |-> (cnt == '0)); // R3 R4
  AST_EVT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_out & ~irq_flags) == '0); // R7
  AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_out & ~$past(evmask)) == '0); // R7
  AST_MASK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(evmask)); // R10
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && wide) |=> cnt == $past(reg_wdata)); // R9
endmodule

// File: tb/rtc_counter_bench.sv
module rtc_counter_bench;
  logic clk = 0, rst_n = 0, tick = 0, reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [6:0] irq_flags, evt_out;
  int checks = 0, errors = 0;
  bit done = 0;

  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];

  always #10 clk = ~clk;

  rtc_counter u_rtc_counter (.clk, .rst_n, .tick, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_flags, .evt_out);

  always @(negedge clk) begin
    if (kq.size() > 0) begin
      int k; logic [31:0] e, act; string t;
      k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
      act = (k == 0) ? reg_rdata : (k == 1) ? 32'(irq_flags) : 32'(evt_out);
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1; tick = 1;
    repeat (n) @(posedge clk);
    #1; tick = 0;
  endtask

  task automatic expect_q(input int kind, input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a; kq.push_back(kind); eq.push_back(e); tq.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    expect_q(0, 0, 32'h2, "R1 control reset");
    expect_q(0, 1, 32'h0, "R1 count reset");
    expect_q(0, 4, 32'h0, "R1 event mask reset");
    expect_q(0, 8, 32'h0, "R1 compare0 reset");
    expect_q(0, 13, 32'h0, "R1 compare5 reset");
    expect_q(1, 0, 32'h0, "R1 flags reset");
    expect_q(2, 0, 32'h0, "R1 events reset");

    wr(0, 3); ticks(5);
    expect_q(0, 1, 32'd5, "R2 five ticks");
    expect_q(1, 0, 32'h0F, "R5 32-bit four channels at zero");
    expect_q(0, 1, 32'd5, "R2 no tick holds");
    wr(0, 2); ticks(3);
    expect_q(0, 1, 32'd5, "R2 stopped holds");

    wr(3, 0);     expect_q(1, 0, 32'h0F, "R8 zero write no effect");
    wr(3, 5);     expect_q(1, 0, 32'h0A, "R8 partial clear");
    wr(3, 'h7F);  expect_q(1, 0, 32'h00, "R8 full clear");

    wr(4, 2); wr(9, 7); wr(10, 7); wr(0, 3);
    wr(4, 'h7F);
    expect_q(0, 4, 32'h2, "R10 mask write while running ignored");
    ticks(2); ticks(1);
    expect_q(2, 0, 32'h02, "R7 masked event pulse");
    expect_q(2, 0, 32'h00, "R7 pulse one cycle");
    expect_q(1, 0, 32'h06, "R5 compares 1 and 2 flagged");

    wr(3, 'h7F); wr(0, 2); wr(8, 3); wr(1, 1); wr(0, 7);
    ticks(3);
    expect_q(0, 1, 32'd0, "R6 clear on compare0 match");
    expect_q(1, 0, 32'h01, "R6 compare0 flag");

    wr(3, 'h7F); wr(0, 2); wr(2, 10); wr(0, 5); wr(1, 1);
    ticks(3);
    expect_q(0, 1, 32'd4, "R6 no clear in 16-bit");
    ticks(6);
    expect_q(0, 1, 32'd10, "R4 count reaches period");
    expect_q(1, 0, 32'h07, "R4 no overflow before wrap");
    ticks(1);
    expect_q(0, 1, 32'd0, "R4 wrap at period");
    expect_q(1, 0, 32'h47, "R4 overflow flag");
    wr(3, 'h7F); ticks(1);
    expect_q(1, 0, 32'h38, "R5 16-bit upper channels");

    wr(0, 2); wr(1, 32'hFFFF_FFFE); wr(3, 'h7F); wr(4, 'h40); wr(0, 3);
    ticks(2);
    expect_q(2, 0, 32'h40, "R7 overflow event");
    expect_q(0, 1, 32'd0, "R3 32-bit wrap");
    expect_q(1, 0, 32'h40, "R3 overflow flag");

    @(posedge clk); #1; tick = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 100;
    @(posedge clk); #1; tick = 0; reg_wr = 0;
    expect_q(0, 1, 32'd100, "R9 write beats tick");
    expect_q(1, 0, 32'h40, "R9 suppressed tick no match");

    repeat (2) @(posedge clk);
    done = 1;
    summary();
  end
endmodule